// File: doc/BRIEF.md
# Masked Read-Modify-Write Configuration Register File

This block interprets a stream of 24-bit command words arriving from a host. Words come in pairs. The first word of a pair is a header that names an operation and a target register. The second word is the operand. One header class ANDs the operand into the chosen register, so every zero bit in the operand clears the matching register bit. The other header class ORs the operand in, so every one bit sets the matching register bit. Because of this, a host can rewrite one field without knowing the rest of the register. It first clears the field with an AND mask and then sets the new code with an OR value.

The bank holds a small set of 24-bit registers selected by the low header byte. The whole bank is visible on a flat output vector. Three fields of the highest register are also decoded for an audio output port: the bit clock ratio, the master clock ratio and the bit clock polarity. A header whose upper bits or register byte are not recognised produces a one-cycle error pulse. The word that follows such a header is dropped.

Top module: `cfg_rmw_regfile`

## Requirements
- R1: While reset is held and in the first cycle after it, every register and decoded field is zero and `cmd_error` is low. `cmd_ready` is low during reset and high from the first clock edge after reset is released.
- R2: A header whose upper 16 bits are 0x8002, followed by a data word, leaves the selected register equal to its old value ANDed with the data word.
- R3: A header whose upper 16 bits are 0x8001, followed by a data word, leaves the selected register equal to its old value ORed with the data word.
- R4: Header low byte 0x7C, 0x7D, 0x7E or 0x7F selects register index 0, 1, 2 or 3 (flat bits [24*i+23:24*i]). Registers that are not selected keep their value.
- R5: `bclk_ratio` equals bits 10:8 of register index 3.
- R6: `mclk_code` is decoded from bits 12:11 of register index 3 as follows: 00 gives 0, 10 gives 1, 11 gives 2, and 01 gives 3.
- R7: `bclk_pol` equals bit 19 of register index 3.
- R8: A header with any other upper 16 bits, or with a low byte outside 0x7C to 0x7F, raises `cmd_error` for exactly the one cycle after it is accepted. The next accepted word is discarded without changing any register, and the word after that is treated as a header.
- R9: A word is consumed only in a cycle with both `cmd_valid` and `cmd_ready` high. Idle cycles between a header and its data word do not break the pairing, and no register changes in a cycle without a transfer.
- R10: The modified value appears on `regs_flat` and on the decoded fields immediately after the clock edge that accepts the data word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command word valid |
| cmd_ready | output | 1 | Block can take a command word |
| cmd_word | input | 24 | Header or data word |
| cmd_error | output | 1 | One-cycle pulse after an unrecognised header |
| regs_flat | output | 96 | All registers, index 0 in the low bits |
| bclk_ratio | output | 3 | Bit clock ratio code |
| mclk_code | output | 2 | Master clock ratio code |
| bclk_pol | output | 1 | Bit clock polarity |

## Verification
The bench builds the block with its default parameters: 24-bit words, four registers and a select base of 0x7C. With these values every register select can be exercised, and so can the select bytes just outside the window on each side, 0x7B and 0x80. Because the field register is the top index, the field-rewrite sequences (clear mask, then set value) run against the same register that the neighbouring registers' writes must leave untouched. The bench also uses gaps of several idle cycles between header and data, and a bad header followed by a word that looks like a valid header, to probe the pairing and discard rules.

// File: rtl/cfg_rmw_pkg.sv
package cfg_rmw_pkg;

    typedef enum logic [1:0] {
        PS_HDR  = 2'd0,
        PS_DATA = 2'd1,
        PS_SKIP = 2'd2
    } parse_state_e;

    typedef enum logic {
        OP_AND = 1'b0,
        OP_OR  = 1'b1
    } rmw_op_e;

endpackage

// File: rtl/cfg_cmd_parser.sv
module cfg_cmd_parser
    import cfg_rmw_pkg::*;
#(
    parameter int unsigned DATA_W   = 24,
    parameter int unsigned NUM_REGS = 4,
    parameter int unsigned BASE_SEL = 'h7C,
    parameter int unsigned HDR_AND  = 'h8002,
    parameter int unsigned HDR_OR   = 'h8001,
    parameter int unsigned IDX_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [DATA_W-1:0] cmd_word,
    output logic              cmd_ready,
    output logic              cmd_error,
    output logic              wr_en,
    output rmw_op_e           wr_op,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data
);

    localparam int unsigned HDR_W = DATA_W - 8;

    typedef struct packed {
        parse_state_e     state;
        rmw_op_e          op;
        logic [IDX_W-1:0] idx;
        logic             err;
        logic             rdy;
    } parse_t;

    parse_t p_d, p_q;

    logic             accept;
    logic [HDR_W-1:0] hdr_hi;
    logic [7:0]       sel_byte;
    logic [7:0]       sel_off;
    logic             is_and;
    logic             is_or;
    logic             sel_ok;

    always_comb begin
        accept   = cmd_valid && p_q.rdy;
        hdr_hi   = cmd_word[DATA_W-1:8];
        sel_byte = cmd_word[7:0];
        sel_off  = sel_byte - 8'(BASE_SEL);
        is_and   = (hdr_hi == HDR_W'(HDR_AND));
        is_or    = (hdr_hi == HDR_W'(HDR_OR));
        sel_ok   = (sel_byte >= 8'(BASE_SEL)) && ({24'd0, sel_off} < 32'(NUM_REGS));

        p_d      = p_q;
        p_d.err  = 1'b0;
        p_d.rdy  = 1'b1;

        unique case (p_q.state)
            PS_HDR: begin
                if (accept) begin
                    if ((is_and || is_or) && sel_ok) begin
                        p_d.state = PS_DATA;
                        p_d.op    = is_or ? OP_OR : OP_AND;
                        p_d.idx   = sel_off[IDX_W-1:0];
                    end else begin
                        p_d.state = PS_SKIP;
                        p_d.err   = 1'b1;
                    end
                end
            end
            PS_DATA: begin
                if (accept) p_d.state = PS_HDR;
            end
            PS_SKIP: begin
                if (accept) p_d.state = PS_HDR;
            end
            default: p_d.state = PS_HDR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '{state: PS_HDR, op: OP_AND, idx: '0, err: 1'b0, rdy: 1'b0};
        end else begin
            p_q <= p_d;
        end
    end

    assign cmd_ready = p_q.rdy;
    assign cmd_error = p_q.err;
    assign wr_en     = (p_q.state == PS_DATA) && accept;
    assign wr_op     = p_q.op;
    assign wr_idx    = p_q.idx;
    assign wr_data   = cmd_word;

endmodule

// File: rtl/cfg_rmw_bank.sv
module cfg_rmw_bank
    import cfg_rmw_pkg::*;
#(
    parameter int unsigned DATA_W   = 24,
    parameter int unsigned NUM_REGS = 4,
    parameter int unsigned IDX_W    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  rmw_op_e                    wr_op,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [DATA_W-1:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                if (wr_op == OP_OR) val_d = val_q | wr_data;
                else                val_d = val_q & wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= '0;
            else        val_q <= val_d;
        end

        assign regs_flat[g*DATA_W +: DATA_W] = val_q;
    end

endmodule

// File: rtl/cfg_field_decode.sv
module cfg_field_decode #(
    parameter int unsigned DATA_W   = 24,
    parameter int unsigned BCLK_LSB = 8,
    parameter int unsigned MCLK_LSB = 11,
    parameter int unsigned POL_BIT  = 19
) (
    input  logic [DATA_W-1:0] field_reg,
    output logic [2:0]        bclk_ratio,
    output logic [1:0]        mclk_code,
    output logic              bclk_pol
);

    logic [1:0] mclk_raw;

    always_comb begin
        bclk_ratio = field_reg[BCLK_LSB +: 3];
        mclk_raw   = field_reg[MCLK_LSB +: 2];
        bclk_pol   = field_reg[POL_BIT];
        unique case (mclk_raw)
            2'b10:   mclk_code = 2'd1;
            2'b11:   mclk_code = 2'd2;
            2'b01:   mclk_code = 2'd3;
            default: mclk_code = 2'd0;
        endcase
    end

endmodule

// File: rtl/cfg_rmw_regfile.sv
module cfg_rmw_regfile
    import cfg_rmw_pkg::*;
#(
    parameter int unsigned DATA_W    = 24,
    parameter int unsigned NUM_REGS  = 4,
    parameter int unsigned BASE_SEL  = 'h7C,
    parameter int unsigned HDR_AND   = 'h8002,
    parameter int unsigned HDR_OR    = 'h8001,
    parameter int unsigned FIELD_IDX = 3,
    parameter int unsigned BCLK_LSB  = 8,
    parameter int unsigned MCLK_LSB  = 11,
    parameter int unsigned POL_BIT   = 19
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid,
    output logic                       cmd_ready,
    input  logic [DATA_W-1:0]          cmd_word,
    output logic                       cmd_error,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat,
    output logic [2:0]                 bclk_ratio,
    output logic [1:0]                 mclk_code,
    output logic                       bclk_pol
);

    localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic              wr_en;
    rmw_op_e           wr_op;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_data;

    cfg_cmd_parser #(
        .DATA_W  (DATA_W),
        .NUM_REGS(NUM_REGS),
        .BASE_SEL(BASE_SEL),
        .HDR_AND (HDR_AND),
        .HDR_OR  (HDR_OR),
        .IDX_W   (IDX_W)
    ) u_parser (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_word (cmd_word),
        .cmd_ready(cmd_ready),
        .cmd_error(cmd_error),
        .wr_en    (wr_en),
        .wr_op    (wr_op),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data)
    );

    cfg_rmw_bank #(
        .DATA_W  (DATA_W),
        .NUM_REGS(NUM_REGS),
        .IDX_W   (IDX_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_op    (wr_op),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .regs_flat(regs_flat)
    );

    cfg_field_decode #(
        .DATA_W  (DATA_W),
        .BCLK_LSB(BCLK_LSB),
        .MCLK_LSB(MCLK_LSB),
        .POL_BIT (POL_BIT)
    ) u_fields (
        .field_reg (regs_flat[FIELD_IDX*DATA_W +: DATA_W]),
        .bclk_ratio(bclk_ratio),
        .mclk_code (mclk_code),
        .bclk_pol  (bclk_pol)
    );

endmodule

// File: rtl/cfg_rmw_checker.sv
module cfg_rmw_checker
    import cfg_rmw_pkg::*;
#(
    parameter int unsigned DATA_W    = 24,
    parameter int unsigned NUM_REGS  = 4,
    parameter int unsigned FIELD_IDX = 3,
    parameter int unsigned BCLK_LSB  = 8,
    parameter int unsigned POL_BIT   = 19
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cmd_valid,
    input logic                       cmd_ready,
    input logic                       cmd_error,
    input logic [NUM_REGS*DATA_W-1:0] regs_flat,
    input logic                       wr_en,
    input rmw_op_e                    wr_op,
    input logic [2:0]                 bclk_ratio,
    input logic                       bclk_pol
);

    p_and_no_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == OP_AND) |=> ((regs_flat & ~$past(regs_flat)) == '0));

    p_or_no_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == OP_OR) |=> (($past(regs_flat) & ~regs_flat) == '0));

    p_bclk_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_ratio == regs_flat[FIELD_IDX*DATA_W + BCLK_LSB +: 3]);

    p_pol_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_pol == regs_flat[FIELD_IDX*DATA_W + POL_BIT]);

    p_err_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_error |=> !cmd_error);

    p_err_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_error |=> $stable(regs_flat));

    p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_ready) |=> $stable(regs_flat));

endmodule

bind cfg_rmw_regfile cfg_rmw_checker #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .FIELD_IDX(FIELD_IDX),
    .BCLK_LSB (BCLK_LSB),
    .POL_BIT  (POL_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_error (cmd_error),
    .regs_flat (regs_flat),
    .wr_en     (wr_en),
    .wr_op     (wr_op),
    .bclk_ratio(bclk_ratio),
    .bclk_pol  (bclk_pol)
);

// File: tb/tb_cfg_rmw_regfile.sv
module tb_cfg_rmw_regfile;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [23:0] cmd_word = '0;
    logic        cmd_ready;
    logic        cmd_error;
    logic [95:0] regs_flat;
    logic [2:0]  bclk_ratio;
    logic [1:0]  mclk_code;
    logic        bclk_pol;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic [95:0] regs;
        logic [5:0]  fields;
        logic        err;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [23:0] model[4];
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_rmw_regfile dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_word  (cmd_word),
        .cmd_error (cmd_error),
        .regs_flat (regs_flat),
        .bclk_ratio(bclk_ratio),
        .mclk_code (mclk_code),
        .bclk_pol  (bclk_pol)
    );

    task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_fields();
        logic [1:0] mc;
        case (model[3][12:11])
            2'b10:   mc = 2'd1;
            2'b11:   mc = 2'd2;
            2'b01:   mc = 2'd3;
            default: mc = 2'd0;
        endcase
        return {model[3][10:8], mc, model[3][19]};
    endfunction

    function automatic logic [95:0] exp_regs();
        return {model[3], model[2], model[1], model[0]};
    endfunction

    task automatic push_exp(input string tag, input logic err);
        exp_t e;
        e.regs   = exp_regs();
        e.fields = exp_fields();
        e.err    = err;
        e.tag    = tag;
        sb_q.push_back(e);
    endtask

    task automatic put_word(input logic [23:0] w);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        cmd_word  = 24'h5A5A5A;
    endtask

    task automatic send(input string tag, input logic [23:0] hdr,
                        input logic [23:0] data, input int gap);
        logic       good;
        logic [1:0] idx;
        good = (hdr[23:8] == 16'h8002 || hdr[23:8] == 16'h8001) &&
               (hdr[7:0] >= 8'h7C) && (hdr[7:0] <= 8'h7F);
        idx  = 2'(hdr[7:0] - 8'h7C);
        put_word(hdr);
        push_exp({tag, " hdr"}, !good);
        for (int k = 0; k < gap; k++) begin
            @(negedge clk);
            push_exp({tag, " gap R9"}, 1'b0);
        end
        put_word(data);
        if (good) begin
            if (hdr[23:8] == 16'h8002) model[idx] = model[idx] & data;
            else                       model[idx] = model[idx] | data;
        end
        push_exp({tag, " data"}, 1'b0);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                check({e.tag, " regs"}, regs_flat, e.regs);
                check({e.tag, " fields R5 R6 R7"}, {90'd0, bclk_ratio, mclk_code, bclk_pol},
                      {90'd0, e.fields});
                check({e.tag, " error R8"}, {95'd0, cmd_error}, {95'd0, e.err});
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        for (int i = 0; i < 4; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        check("R1 regs in reset", regs_flat, '0);
        check("R1 ready low in reset", {95'd0, cmd_ready}, 96'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 regs after reset", regs_flat, '0);
        check("R1 fields after reset", {90'd0, bclk_ratio, mclk_code, bclk_pol}, 96'd0);
        check("R1 error after reset", {95'd0, cmd_error}, 96'd0);
        check("R1 ready after reset", {95'd0, cmd_ready}, 96'd1);

        send("R3 R5 R10 or bclk", 24'h80017F, 24'h000200, 0);
        send("R2 clear bclk",     24'h80027F, 24'hFFF8FF, 0);
        send("R5 bclk code3",     24'h80017F, 24'h000300, 0);
        send("R6 clear mclk",     24'h80027F, 24'hFFE7FF, 0);
        send("R6 mclk code1",     24'h80017F, 24'h001000, 0);
        send("R6 clear mclk",     24'h80027F, 24'hFFE7FF, 0);
        send("R6 mclk code2",     24'h80017F, 24'h001800, 0);
        send("R6 clear mclk",     24'h80027F, 24'hFFE7FF, 0);
        send("R6 mclk code3",     24'h80017F, 24'h000800, 0);
        send("R7 pol set",        24'h80017F, 24'h080000, 0);
        send("R7 pol clear",      24'h80027F, 24'hF7FFFF, 0);
        send("R4 reg 7C",         24'h80017C, 24'hF01F00, 0);
        send("R4 reg 7D",         24'h80017D, 24'h123456, 0);
        send("R4 reg 7E",         24'h80017E, 24'hABCDEF, 0);
        send("R2 R4 and 7D",      24'h80027D, 24'h00FF00, 0);
        send("R9 gap or 7C",      24'h80017C, 24'h0000A5, 3);
        send("R9 gap and 7E",     24'h80027E, 24'hFF00FF, 5);
        send("R8 bad upper",      24'h80037F, 24'hFFFFFF, 0);
        send("R8 low 7B",         24'h80017B, 24'hFFFFFF, 0);
        send("R8 low 80",         24'h800180, 24'hFFFFFF, 2);
        send("R8 discard hdr-like", 24'h123456, 24'h80017F, 0);
        send("R8 next is header", 24'h80017E, 24'h000001, 0);
        send("R2 full clear 7F",  24'h80027F, 24'h000000, 0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule